// File: doc/BRIEF.md
# Sticky Clear-On-Read Error Status Register

This block keeps a byte-wide, read-only error status word for an audio serial-port datapath. Seven event inputs feed it: a serial clock error (the ratio between the master clock and the frame clock is not valid) and overflow indications from two DSP paths, two PCM paths and two ADC paths. Each input sets its own flag, and the flag stays set until software reads the word. Each flag therefore reports whether its condition happened at least once since the previous read.

A read is a single-cycle strobe from a simple register bus. The bus samples the read data during the strobe cycle and sees the flags as they were before the clear. All flags then clear together at the next clock edge. An event that arrives in the same cycle as the read survives the clear, so the next read reports it. After reset the clock-error flag starts set, which reflects that the serial port has to resynchronize once clocks first run.

Top module: `stsreg_top`

## Requirements
- R1: Bit 7 of `rd_data` is reserved and reads 0 at all times.
- R2: Bit positions are fixed: 6 = serial clock error, 5 = DSP A overflow, 4 = DSP B overflow, 3 = PCM A overflow, 2 = PCM B overflow, 1 = ADC A overflow, 0 = ADC B overflow. An input that is high during a cycle makes its bit read 1 from the next rising edge on.
- R3: A bit that is set stays 1 until a read, and no bit becomes 1 unless its event input was high.
- R4: During a cycle with `rd_stb` high, `rd_data` shows the flags from before the clear. After that edge, every bit whose event was low in the strobe cycle reads 0.
- R5: When an event is high in the same cycle as `rd_stb`, its bit reads 1 after the clear.
- R6: After reset `rd_data` equals 8'h40: the serial clock error bit is set and all other bits are 0.
- R7: An event input held high as a level keeps its bit at 1 across any number of reads.
- R8: Events on different inputs in separate cycles accumulate. The word is the OR of all flags raised since the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_clk_err | input | 1 | Master-to-frame clock ratio not valid |
| evt_dsp_a_ovf | input | 1 | DSP path A overflow |
| evt_dsp_b_ovf | input | 1 | DSP path B overflow |
| evt_pcm_a_ovf | input | 1 | PCM path A overflow |
| evt_pcm_b_ovf | input | 1 | PCM path B overflow |
| evt_adc_a_ovf | input | 1 | ADC path A overflow |
| evt_adc_b_ovf | input | 1 | ADC path B overflow |
| rd_stb | input | 1 | Single-cycle read strobe; clears all flags |
| rd_data | output | 8 | Status word |

## Verification
The bench builds the block with its default parameters. With those defaults the clock-error flag resets to 1 and all other flags reset to 0, which puts the power-up resynchronization state within reach of a read right after reset. Directed tasks walk a single event across every bit position and collect overlapping events. They also place an event in the strobe cycle itself to exercise the read/set collision, and hold an input as a level across reads.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

    localparam int FLAG_N = 7;
    localparam int REG_W  = 8;

    // bit positions decoded by the register bus consumer
    localparam int IDX_ADC_B = 0;
    localparam int IDX_ADC_A = 1;
    localparam int IDX_PCM_B = 2;
    localparam int IDX_PCM_A = 3;
    localparam int IDX_DSP_B = 4;
    localparam int IDX_DSP_A = 5;
    localparam int IDX_CLK   = 6;

    typedef struct packed {
        logic sticky;
    } flag_state_t;

endpackage

// File: rtl/stsreg_flag.sv
module stsreg_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic flag_o
);
    import stsreg_pkg::*;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // a concurrent event wins over the clear
        st_d.sticky = (st_q.sticky & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sticky <= RST_VAL;
        else        st_q        <= st_d;
    end

    assign flag_o = st_q.sticky;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_o);                                   // R2
    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);                      // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !evt_i) |=> !flag_o);                    // R3
    AST_CLR_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !flag_o);                      // R4

endmodule

// File: rtl/stsreg_rdmux.sv
module stsreg_rdmux
    import stsreg_pkg::*;
(
    input  logic [FLAG_N-1:0] flags_i,
    output logic [REG_W-1:0]  word_o
);
    localparam int RSV_W = REG_W - FLAG_N;

    always_comb begin
        word_o = '0;
        word_o[FLAG_N-1:0] = flags_i;
        word_o[REG_W-1:FLAG_N] = {RSV_W{1'b0}};
    end

endmodule

// File: rtl/stsreg_top.sv
module stsreg_top #(
    parameter logic CLKERR_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_clk_err,
    input  logic       evt_dsp_a_ovf,
    input  logic       evt_dsp_b_ovf,
    input  logic       evt_pcm_a_ovf,
    input  logic       evt_pcm_b_ovf,
    input  logic       evt_adc_a_ovf,
    input  logic       evt_adc_b_ovf,
    input  logic       rd_stb,
    output logic [7:0] rd_data
);
    import stsreg_pkg::*;

    logic [FLAG_N-1:0] evt_vec;
    logic [FLAG_N-1:0] flag_vec;

    always_comb begin
        evt_vec            = '0;
        evt_vec[IDX_CLK]   = evt_clk_err;
        evt_vec[IDX_DSP_A] = evt_dsp_a_ovf;
        evt_vec[IDX_DSP_B] = evt_dsp_b_ovf;
        evt_vec[IDX_PCM_A] = evt_pcm_a_ovf;
        evt_vec[IDX_PCM_B] = evt_pcm_b_ovf;
        evt_vec[IDX_ADC_A] = evt_adc_a_ovf;
        evt_vec[IDX_ADC_B] = evt_adc_b_ovf;
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        localparam logic RV = (g == IDX_CLK) ? CLKERR_RST : 1'b0;
        stsreg_flag #(.RST_VAL(RV)) i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_vec[g]),
            .clr_i  (rd_stb),
            .flag_o (flag_vec[g])
        );
    end

    stsreg_rdmux i_rdmux (
        .flags_i (flag_vec),
        .word_o  (rd_data)
    );

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0);                                 // R1
    AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clk_err && rd_stb) |=> rd_data[6]);             // R5

endmodule

// File: tb/test_stsreg_top.sv
module test_stsreg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt = '0;
    logic [6:0] hold = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    int         errors = 0;
    int         checks = 0;
    logic [7:0] pre;

    always #2ns clk = ~clk;

    stsreg_top i_stsreg_top (
        .clk(clk), .rst_n(rst_n),
        .evt_clk_err(evt[6]), .evt_dsp_a_ovf(evt[5]), .evt_dsp_b_ovf(evt[4]),
        .evt_pcm_a_ovf(evt[3]), .evt_pcm_b_ovf(evt[2]),
        .evt_adc_a_ovf(evt[1]), .evt_adc_b_ovf(evt[0]),
        .rd_stb(rd_stb), .rd_data(rd_data)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock cycle of stimulus; out returns rd_data before the edge
    task automatic cyc(input logic [6:0] ev, input logic rd, output logic [7:0] out);
        @(negedge clk);
        evt = ev | hold; rd_stb = rd;
        #1ns out = rd_data;
        @(negedge clk);
        evt = hold; rd_stb = 1'b0;
        #1ns;
    endtask

    task automatic t_reset;
        chk(rd_data, 8'h40, "R6 reset value");
        cyc(7'h00, 1'b1, pre);
        chk(pre, 8'h40, "R4 read returns pre-clear");
        chk(rd_data, 8'h00, "R4 cleared after read");
    endtask

    task automatic t_walk;
        for (int i = 0; i < 7; i++) begin
            cyc(7'(1 << i), 1'b0, pre);
            chk(rd_data, 8'(1 << i), "R2 bit position");
            cyc(7'h00, 1'b1, pre);
            chk(pre, 8'(1 << i), "R4 read value");
            chk(rd_data, 8'h00, "R4 clear");
        end
    endtask

    task automatic t_hold;
        cyc(7'h08, 1'b0, pre);
        for (int i = 0; i < 5; i++) cyc(7'h00, 1'b0, pre);
        chk(rd_data, 8'h08, "R3 sticky without read");
        cyc(7'h00, 1'b1, pre);
        chk(rd_data, 8'h00, "R3 no spurious set after clear");
    endtask

    task automatic t_accum;
        cyc(7'h01, 1'b0, pre);
        cyc(7'h20, 1'b0, pre);
        cyc(7'h01, 1'b0, pre);
        chk(rd_data, 8'h21, "R8 accumulate");
    endtask

    task automatic t_same_cycle;
        cyc(7'h04, 1'b1, pre);
        chk(pre, 8'h21, "R5 pre-clear value");
        chk(rd_data, 8'h04, "R5 event during read kept");
        cyc(7'h00, 1'b1, pre);
        chk(rd_data, 8'h00, "R5 cleared on next read");
    endtask

    task automatic t_level;
        hold = 7'h42;
        cyc(7'h00, 1'b0, pre);
        chk(rd_data, 8'h42, "R7 level sets");
        cyc(7'h00, 1'b1, pre);
        cyc(7'h00, 1'b1, pre);
        chk(rd_data, 8'h42, "R7 level survives reads");
        hold = 7'h00;
        cyc(7'h00, 1'b0, pre);
        chk(rd_data, 8'h42, "R7 sticky after level drops");
        cyc(7'h00, 1'b1, pre);
        chk(rd_data, 8'h00, "R7 clears after level gone");
    endtask

    task automatic t_all;
        cyc(7'h7f, 1'b0, pre);
        chk(rd_data, 8'h7f, "R1 all flags, bit 7 zero");
        cyc(7'h00, 1'b1, pre);
        chk(pre, 8'h7f, "R1 read value");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1ns;
        t_reset;
        t_walk;
        t_hold;
        t_accum;
        t_same_cycle;
        t_level;
        t_all;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100us;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule